// File: doc/BRIEF.md
# Receive Queue Redirection Table

This block maps a packet's receive hash onto one of up to eight receive queues. It keeps a 128-entry table of queue indices. A lookup port takes a 32-bit hash, uses its low seven bits as the table index, and one clock later returns the 3-bit queue held in that entry, together with a valid flag.

Software reaches the table through a word-wide register port. Each 32-bit register holds four entries, one per byte. Byte strobes let a single entry change while its three neighbours keep their values. A fill sequencer can instead write a default pattern over the whole table, assigning queues 0 to Q-1 in rotation for a queue count Q given at start. The fill is skipped when software has written the table since the last stop event, so a hand-built table survives a restart. A stop event re-arms the default fill.

Top module: `rss_redirect_table`

## Requirements
- R1: The table index is hash bits 6:0. Entry n is held in register n>>2, in byte lane n&3, and lane 0 occupies bits 7:0 of the register.
- R2: `lk_valid_o` and `lk_queue_o` appear exactly one clock after the lookup request. `lk_valid_o` is high only in the cycle after a cycle with `lk_valid_i` high.
- R3: All eight bits of every entry are stored and read back. Only bits 2:0 of an entry drive `lk_queue_o`, and bits 7:3 have no effect on it.
- R4: A register write changes only the byte lanes whose `reg_be_i` bit is set. The other lanes keep their previous contents.
- R5: An accepted read (`reg_re_i` high while `reg_ready_o` is high) returns the addressed word on `reg_rdata_o` one clock later, with `reg_rvalid_o` high in that cycle only.
- R6: When a lookup and a write to the same entry occur in the same cycle, the lookup returns the value the entry held before the write.
- R7: A default fill sets entry n to n mod Q, for all 128 entries.
- R8: A requested queue count of 0 is treated as 1. Counts above 8 are treated as 8.
- R9: A started fill holds `busy_o` high for exactly 128 cycles and `reg_ready_o` low for the same cycles. A write presented only while `busy_o` is high is not accepted and changes no entry.
- R10: An accepted software write sets an internal updated flag. While that flag is set, `fill_start_i` starts no fill and leaves the table unchanged. A pulse on `stop_i` clears the flag.
- R11: After reset, `busy_o`, `lk_valid_o` and `reg_rvalid_o` are low, `reg_ready_o` is high, and the updated flag is clear, so the first fill request is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Stop event; clears the updated flag |
| fill_start_i | input | 1 | Request a default fill |
| fill_qcnt_i | input | 4 | Queue count used by the fill |
| busy_o | output | 1 | Fill in progress |
| reg_ready_o | output | 1 | Register port accepts an access |
| reg_we_i | input | 1 | Register write |
| reg_re_i | input | 1 | Register read |
| reg_be_i | input | 4 | Byte-lane write strobes |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data |
| reg_rvalid_o | output | 1 | Read data valid |
| lk_valid_i | input | 1 | Lookup request |
| lk_hash_i | input | 32 | Hash to look up |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_queue_o | output | 3 | Selected queue index |

## Verification
The hardest condition to reach from the ports is a write that arrives while the sequencer owns the table. The bench drives a full-word write for a single cycle in the middle of a fill and drops it. After the fill it reads every word back, to show that the rotation pattern was not disturbed. Two other cases need the stimulus timed exactly: a lookup and a write to the same entry in the same cycle, and a fill request made while the updated flag is set. For the second case, a stop pulse followed by two further fills, with queue counts of 0 and 12, exercises the clamping rules.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int unsigned RSS_ENTRIES = 128;
  localparam int unsigned RSS_REG_W   = 32;
  localparam int unsigned RSS_LANE_W  = 8;
  localparam int unsigned RSS_QIDX_W  = 3;
  localparam int unsigned RSS_QCNT_W  = 4;
  localparam int unsigned RSS_HASH_W  = 32;
endpackage

// File: rtl/rss_tbl_mem.sv
module rss_tbl_mem #(
  parameter int unsigned WORDS  = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned AW     = 5,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [AW-1:0]    a_addr,
  output logic [DW-1:0]    a_rdata,
  input  logic             b_we,
  input  logic [LANES-1:0] b_be,
  input  logic             b_re,
  input  logic [AW-1:0]    b_addr,
  input  logic [DW-1:0]    b_wdata,
  output logic [DW-1:0]    b_rdata
);
  // One narrow RAM per byte lane, each with its own write enable
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] ram [WORDS];
    logic [LANE_W-1:0] a_q;
    logic [LANE_W-1:0] b_q;

    always_ff @(posedge clk) begin
      if (b_we && b_be[l]) ram[b_addr] <= b_wdata[l*LANE_W +: LANE_W];
      a_q <= ram[a_addr];
      if (b_re) b_q <= ram[b_addr];
    end

    assign a_rdata[l*LANE_W +: LANE_W] = a_q;
    assign b_rdata[l*LANE_W +: LANE_W] = b_q;
  end
endmodule

// File: rtl/rss_fill_seq.sv
module rss_fill_seq #(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned QIDX_W  = 3,
  parameter int unsigned QCNT_W  = 4,
  localparam int unsigned DW     = LANES * LANE_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned LSEL_W = $clog2(LANES),
  localparam int unsigned AW     = IDX_W - LSEL_W,
  localparam int unsigned MAXQ   = 1 << QIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [QCNT_W-1:0] qcnt,
  output logic              busy,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [DW-1:0]     wdata
);
  logic [IDX_W-1:0]  cnt_q;
  logic [QIDX_W-1:0] qn_q;
  logic [QIDX_W:0]   qlim_q;
  logic [DW-1:0]     acc_q;
  logic [QIDX_W:0]   qeff;
  logic [QIDX_W:0]   qn_inc;
  logic [LANE_W-1:0] entry;

  always_comb begin
    if (qcnt == '0)                         qeff = (QIDX_W+1)'(1);
    else if (32'(qcnt) > MAXQ)              qeff = (QIDX_W+1)'(MAXQ);
    else                                    qeff = (QIDX_W+1)'(qcnt);
  end

  assign qn_inc = {1'b0, qn_q} + 1'b1;
  assign entry  = LANE_W'(qn_q);
  assign we     = busy && (cnt_q[LSEL_W-1:0] == '1);
  assign waddr  = cnt_q[IDX_W-1:LSEL_W];
  assign wdata  = {entry, acc_q[DW-1:LANE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      qn_q   <= '0;
      qlim_q <= (QIDX_W+1)'(1);
      acc_q  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        cnt_q  <= '0;
        qn_q   <= '0;
        qlim_q <= qeff;
        acc_q  <= '0;
      end
    end else begin
      acc_q <= wdata;
      cnt_q <= cnt_q + 1'b1;
      qn_q  <= (qn_inc == qlim_q) ? '0 : qn_inc[QIDX_W-1:0];
      if (cnt_q == '1) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/rss_lookup_out.sv
module rss_lookup_out #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned QIDX_W = 3,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned LSEL_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LSEL_W-1:0] req_lane,
  input  logic [DW-1:0]     word_q,
  output logic              valid_o,
  output logic [QIDX_W-1:0] queue_o
);
  logic [LSEL_W-1:0] lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      lane_q  <= '0;
    end else begin
      valid_o <= req_valid;
      lane_q  <= req_lane;
    end
  end

  // word_q is already registered in the RAM; pick the low bits of the lane
  always_comb begin
    queue_o = '0;
    for (int l = 0; l < LANES; l++)
      if (lane_q == LSEL_W'(l)) queue_o = word_q[l*LANE_W +: QIDX_W];
  end
endmodule

// File: rtl/rss_redirect_table.sv
module rss_redirect_table
  import rss_pkg::*;
#(
  parameter int unsigned ENTRIES = RSS_ENTRIES,
  parameter int unsigned REG_W   = RSS_REG_W,
  parameter int unsigned LANE_W  = RSS_LANE_W,
  parameter int unsigned QIDX_W  = RSS_QIDX_W,
  parameter int unsigned QCNT_W  = RSS_QCNT_W,
  parameter int unsigned HASH_W  = RSS_HASH_W,
  localparam int unsigned LANES  = REG_W / LANE_W,
  localparam int unsigned WORDS  = ENTRIES / LANES,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned LSEL_W = $clog2(LANES),
  localparam int unsigned AW     = IDX_W - LSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_i,
  input  logic              fill_start_i,
  input  logic [QCNT_W-1:0] fill_qcnt_i,
  output logic              busy_o,
  output logic              reg_ready_o,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [LANES-1:0]  reg_be_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              reg_rvalid_o,
  input  logic              lk_valid_i,
  input  logic [HASH_W-1:0] lk_hash_i,
  output logic              lk_valid_o,
  output logic [QIDX_W-1:0] lk_queue_o
);
  logic             upd_q;
  logic             sw_we;
  logic             sw_re;
  logic             fill_go;
  logic             f_we;
  logic [AW-1:0]    f_addr;
  logic [REG_W-1:0] f_data;
  logic             m_we;
  logic [LANES-1:0] m_be;
  logic [AW-1:0]    m_addr;
  logic [REG_W-1:0] m_wdata;
  logic [REG_W-1:0] lk_word;

  assign reg_ready_o = !busy_o;
  assign sw_we       = reg_we_i && !busy_o;
  assign sw_re       = reg_re_i && !busy_o;
  assign fill_go     = fill_start_i && !upd_q && !busy_o;

  // Updated flag: stop wins over a write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)         upd_q <= 1'b0;
    else if (stop_i) upd_q <= 1'b0;
    else if (sw_we)  upd_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rvalid_o <= 1'b0;
    else     reg_rvalid_o <= sw_re;
  end

  // Write port belongs to the sequencer while it is busy
  assign m_we    = busy_o ? f_we   : sw_we;
  assign m_be    = busy_o ? '1     : reg_be_i;
  assign m_addr  = busy_o ? f_addr : reg_addr_i;
  assign m_wdata = busy_o ? f_data : reg_wdata_i;

  rss_fill_seq #(
    .ENTRIES(ENTRIES), .LANES(LANES), .LANE_W(LANE_W),
    .QIDX_W(QIDX_W), .QCNT_W(QCNT_W)
  ) u_fill (
    .clk(clk), .rst(rst), .start(fill_go), .qcnt(fill_qcnt_i),
    .busy(busy_o), .we(f_we), .waddr(f_addr), .wdata(f_data)
  );

  rss_tbl_mem #(
    .WORDS(WORDS), .LANES(LANES), .LANE_W(LANE_W), .AW(AW)
  ) u_mem (
    .clk(clk),
    .a_addr(lk_hash_i[IDX_W-1:LSEL_W]), .a_rdata(lk_word),
    .b_we(m_we), .b_be(m_be), .b_re(sw_re), .b_addr(m_addr),
    .b_wdata(m_wdata), .b_rdata(reg_rdata_o)
  );

  rss_lookup_out #(
    .LANES(LANES), .LANE_W(LANE_W), .QIDX_W(QIDX_W)
  ) u_out (
    .clk(clk), .rst(rst), .req_valid(lk_valid_i),
    .req_lane(lk_hash_i[LSEL_W-1:0]), .word_q(lk_word),
    .valid_o(lk_valid_o), .queue_o(lk_queue_o)
  );
endmodule

// File: rtl/rss_table_chk.sv
module rss_table_chk #(
  parameter int unsigned ENTRIES = 128,
  localparam int unsigned CW = $clog2(ENTRIES + 1)
) (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic fill_start_i,
  input logic upd,
  input logic lk_valid_i,
  input logic lk_valid_o,
  input logic reg_re_i,
  input logic reg_rvalid_o
);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)         bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + 1'b1;
    else             bcnt <= '0;
  end

  assert_fill_len_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (32'(bcnt) == ENTRIES));

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (32'(bcnt) < ENTRIES));

  assert_fill_skip_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(fill_start_i) && !$past(upd)));

  assert_lk_lat_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid_i |=> lk_valid_o);

  assert_lk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> !lk_valid_o);

  assert_rd_lat_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_re_i && !busy_o) |=> reg_rvalid_o);

  assert_rd_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !(reg_re_i && !busy_o) |=> !reg_rvalid_o);
endmodule

bind rss_redirect_table rss_table_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .fill_start_i(fill_start_i),
  .upd(upd_q), .lk_valid_i(lk_valid_i), .lk_valid_o(lk_valid_o),
  .reg_re_i(reg_re_i), .reg_rvalid_o(reg_rvalid_o)
);

// File: tb/sim_rss_redirect_table.sv
module sim_rss_redirect_table;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stop_i = 1'b0, fill_start_i = 1'b0;
  logic [3:0]  fill_qcnt_i = '0;
  logic        busy_o, reg_ready_o;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0]  reg_be_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        reg_rvalid_o;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_hash_i = '0;
  logic        lk_valid_o;
  logic [2:0]  lk_queue_o;

  always #4 clk = ~clk;

  rss_redirect_table u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [128];
  logic [31:0] lk_exp_q [$];
  string       lk_tag_q [$];
  logic [31:0] rd_exp_q [$];
  string       rd_tag_q [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(int a);
    return {model[4*a+3], model[4*a+2], model[4*a+1], model[4*a]};
  endfunction

  // Monitor: pops expected items as the design produces results
  always @(negedge clk) begin
    if (!rst && lk_valid_o) begin
      if (lk_exp_q.size() == 0) check("R2 unexpected lookup", 32'd1, 32'd0);
      else check(lk_tag_q.pop_front(), 32'(lk_queue_o), lk_exp_q.pop_front());
    end
    if (!rst && reg_rvalid_o) begin
      if (rd_exp_q.size() == 0) check("R5 unexpected read", 32'd1, 32'd0);
      else check(rd_tag_q.pop_front(), reg_rdata_o, rd_exp_q.pop_front());
    end
  end

  task automatic lookup(logic [31:0] h, string tag);
    @(negedge clk);
    lk_valid_i = 1'b1; lk_hash_i = h;
    lk_exp_q.push_back(32'(model[h[6:0]][2:0])); lk_tag_q.push_back(tag);
    @(negedge clk);
    lk_valid_i = 1'b0;
  endtask

  task automatic wr(int a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    while (!reg_ready_o) @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 5'(a); reg_be_i = be; reg_wdata_i = d;
    for (int l = 0; l < 4; l++) if (be[l]) model[4*a+l] = d[8*l +: 8];
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    while (!reg_ready_o) @(negedge clk);
    reg_re_i = 1'b1; reg_addr_i = 5'(a);
    rd_exp_q.push_back(mword(a)); rd_tag_q.push_back(tag);
    @(negedge clk);
    reg_re_i = 1'b0;
  endtask

  task automatic fill(logic [3:0] q, int eff, bit stall_try);
    int n = 0;
    @(negedge clk);
    fill_start_i = 1'b1; fill_qcnt_i = q;
    @(negedge clk);
    fill_start_i = 1'b0;
    while (busy_o && n < 1000) begin
      n++;
      if (stall_try && n == 6) begin
        check("R9 ready low while busy", 32'(reg_ready_o), 32'd0);
        reg_we_i = 1'b1; reg_addr_i = 5'd0; reg_be_i = 4'hF; reg_wdata_i = 32'hFFFF_FFFF;
      end else reg_we_i = 1'b0;
      @(negedge clk);
    end
    reg_we_i = 1'b0;
    check("R9 fill busy cycles", 32'(n), 32'd128);
    for (int i = 0; i < 128; i++) model[i] = 8'(i % eff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 busy after reset", 32'(busy_o), 32'd0);
    check("R11 lk_valid after reset", 32'(lk_valid_o), 32'd0);
    check("R11 rvalid after reset", 32'(reg_rvalid_o), 32'd0);
    check("R11 ready after reset", 32'(reg_ready_o), 32'd1);

    // R7 R9: fill with 3 queues, a one-cycle write attempt in the middle
    fill(4'd3, 3, 1'b1);
    for (int a = 0; a < 32; a++) rd(a, "R7 R9 fill pattern q=3");
    // R1 R2: lookups, upper hash bits ignored, lane order
    lookup(32'hDEAD_BE80, "R1 hash low bits 0");
    lookup(32'h0000_0005, "R1 entry 5");
    lookup(32'h1234_567F, "R1 entry 127");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      lk_valid_i = 1'b1; lk_hash_i = 32'(i * 21 + 3);
      lk_exp_q.push_back(32'(model[7'(i * 21 + 3)][2:0])); lk_tag_q.push_back("R2 back-to-back");
    end
    @(negedge clk); lk_valid_i = 1'b0;

    // R4 R3: partial write, upper bits stored but not used
    wr(5, 4'b0101, 32'hE9A2_F3C4);
    rd(5, "R4 R3 lane mask readback");
    lookup(32'd20, "R3 lane0 0xC4 -> 4");
    lookup(32'd21, "R4 lane1 kept");
    lookup(32'd22, "R3 lane2 0xA2 -> 2");
    lookup(32'd23, "R4 lane3 kept");

    // R6: write and lookup of the same entry in one cycle
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 5'd5; reg_be_i = 4'b0010; reg_wdata_i = 32'h0000_0600;
    lk_valid_i = 1'b1; lk_hash_i = 32'd21;
    lk_exp_q.push_back(32'(model[21][2:0])); lk_tag_q.push_back("R6 old value on collision");
    model[21] = 8'h06;
    @(negedge clk);
    reg_we_i = 1'b0; lk_valid_i = 1'b0;
    lookup(32'd21, "R6 new value after write");

    // R10: fill request while updated flag is set is ignored
    @(negedge clk); fill_start_i = 1'b1; fill_qcnt_i = 4'd2;
    @(negedge clk); fill_start_i = 1'b0;
    check("R10 no fill when updated", 32'(busy_o), 32'd0);
    rd(5, "R10 table unchanged");
    rd(0, "R10 table unchanged word0");

    // R10 R8: stop clears the flag; count 0 acts as 1
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    fill(4'd0, 1, 1'b0);
    rd(9, "R8 q=0 pattern");
    lookup(32'd77, "R8 q=0 lookup");
    // R8: count 12 clamps to 8
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    fill(4'd12, 8, 1'b0);
    rd(1, "R8 q=12 clamped word1");
    rd(31, "R8 q=12 clamped word31");
    lookup(32'd15, "R8 q=12 lookup 15");

    repeat (4) @(negedge clk);
    check("R2 lookup queue drained", 32'(lk_exp_q.size()), 32'd0);
    check("R5 read queue drained", 32'(rd_exp_q.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule